// File: doc/BRIEF.md
# Reloadable Up/Down Event Counter

This block is one 16-bit counter channel that advances on edges of an external event signal instead of on the system clock. Software programs the channel through a small two-register write port. A control word selects the active edge, where the count direction comes from, whether a toggling output pin is driven, whether the channel runs, and whether it decodes a two-phase input pair. A reload word holds the value the counter restarts from.

When the count passes its end of range, the counter restarts from the reload value and raises a single-cycle request. The end of range is 0x0000 when counting down and 0xFFFF when counting up. With reload value n, the request repeats every n+1 events when counting down and every 0xFFFF−n+1 events when counting up. All three external inputs are asynchronous. Each one passes through a two-flop synchronizer, and the counter moves by at most one step per clock.

Top module: `ec_counter_top`

## Requirements
- R1: After reset, count_o is 0x0000, irq_o is 0 and pulse_o is 0, and every control bit is 0, so the channel is stopped.
- R2: Writing address 1 while the run bit (control bit 0) is 0 stores the reload value and also places it in count_o on the following cycle.
- R3: Counting down with reload value n gives one terminal event every n+1 counted edges. The terminal event fires when the counter is at 0x0000, and the counter then reloads to n.
- R4: Counting up with reload value n gives one terminal event every 0xFFFF−n+1 counted edges. The terminal event fires when the counter is at 0xFFFF, and the counter then reloads to n.
- R5: A terminal event asserts irq_o for exactly the cycle in which count_o shows the reloaded value.
- R6: Control bit 1 selects the counted edge of evt_i: 1 counts rising edges and 0 counts falling edges. An edge of the other polarity leaves count_o unchanged.
- R7: Control bit 2 selects the direction source. When it is 0, control bit 3 sets the direction (0 down, 1 up). When it is 1, the synchronized level of dir_i sets it (low down, high up).
- R8: Control bit 4 enables the pulse output. While it is set, pulse_o toggles on every terminal event. While it is clear, pulse_o is 0.
- R9: While the run bit is 0, event edges do not change count_o.
- R10: Writing the reload register while the channel runs does not alter count_o. The new value is used at the next terminal event.
- R11: When control bit 5 is set, both edges of evt_i (phase A) count. A rising edge seen while phb_i is low counts up, and every other edge counts down. Control bits 2 and 3 and dir_i have no effect in this mode.
- R12: count_o changes by at most one step per clock, except when a load or reload takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select: 0 control, 1 reload |
| wr_data | input | 16 | Write data; control uses bits 5:0 |
| evt_i | input | 1 | Asynchronous event input (phase A in two-phase mode) |
| dir_i | input | 1 | Asynchronous direction pin |
| phb_i | input | 1 | Asynchronous phase B input |
| count_o | output | 16 | Current counter value |
| irq_o | output | 1 | One-cycle terminal-event request |
| pulse_o | output | 1 | Toggling pulse output |

## Verification
The hardest situations to reach from the ports are the two boundary crossings: the wrap past 0xFFFF when counting up and the wrap past 0x0000 when counting down. Counting there from reset would take tens of thousands of events. The stimulus avoids this by loading a reload value close to the boundary while the channel is stopped, such as 0xFFFC for up counting or 3 for down counting. The crossing then happens after only a few events, and the bench checks the counter value and the request count on each side of it. Two-phase decoding is reached the same way. The bench loads a mid-range value and then moves phase A while holding phase B at each level, and it checks the result after every single edge.

// File: rtl/ec_pkg.sv
package ec_pkg;
  typedef struct packed {
    logic quad;      // bit 5: two-phase decode
    logic pulse_en;  // bit 4: toggle output enable
    logic sw_up;     // bit 3: software direction, 1 = up
    logic dir_pin;   // bit 2: direction from dir_i
    logic rise;      // bit 1: 1 = rising edge, 0 = falling edge
    logic run;       // bit 0: counting enabled
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ec_sync.sv
module ec_sync #(
  parameter int STAGES = 2,
  parameter int N      = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [STAGES-1:0] chain [N];

  for (genvar b = 0; b < N; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) chain[b] <= '0;
      else     chain[b] <= {chain[b][STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain[b][STAGES-1];
  end
endmodule

// File: rtl/ec_ctrl_regs.sv
module ec_ctrl_regs
  import ec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output ctrl_t            ctrl_q,
  output logic [CNT_W-1:0] reload_q,
  output logic             load_now,
  output logic [CNT_W-1:0] load_val
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else if (wr_en) begin
      if (wr_addr) reload_q <= wr_data;
      else         ctrl_q   <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end
  end

  // immediate counter load only when the channel is stopped
  assign load_now = wr_en & wr_addr & ~ctrl_q.run;
  assign load_val = wr_data;
endmodule

// File: rtl/ec_step_sel.sv
module ec_step_sel
  import ec_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t ctrl_q,
  input  logic  a_lvl,
  input  logic  b_lvl,
  input  logic  dir_lvl,
  output logic  step_en,
  output logic  step_up
);
  logic a_prev;
  logic a_rise, a_fall;
  logic edge_hit;

  always_ff @(posedge clk) begin
    if (rst) a_prev <= 1'b0;
    else     a_prev <= a_lvl;
  end

  assign a_rise = a_lvl & ~a_prev;
  assign a_fall = ~a_lvl & a_prev;

  always_comb begin
    if (ctrl_q.quad) begin
      edge_hit = a_rise | a_fall;
      step_up  = a_rise & ~b_lvl;
    end else begin
      edge_hit = ctrl_q.rise ? a_rise : a_fall;
      step_up  = ctrl_q.dir_pin ? dir_lvl : ctrl_q.sw_up;
    end
  end

  assign step_en = ctrl_q.run & edge_hit;
endmodule

// File: rtl/ec_count_core.sv
module ec_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_now,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_q,
  input  logic             step_en,
  input  logic             step_up,
  input  logic             pulse_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_q,
  output logic             pulse_q
);
  localparam logic [CNT_W-1:0] TOP = '1;
  localparam logic [CNT_W-1:0] BOT = '0;

  logic term;
  assign term = step_en & (step_up ? (cnt_q == TOP) : (cnt_q == BOT));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      irq_q <= term;
      if (load_now)     cnt_q <= load_val;
      else if (term)    cnt_q <= reload_q;
      else if (step_en) cnt_q <= step_up ? cnt_q + 1'b1 : cnt_q - 1'b1;

      if (!pulse_en)    pulse_q <= 1'b0;
      else if (term)    pulse_q <= ~pulse_q;
    end
  end
endmodule

// File: rtl/ec_counter_top.sv
module ec_counter_top
  import ec_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             evt_i,
  input  logic             dir_i,
  input  logic             phb_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic             pulse_o
);
  localparam int N_IN = 3;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             load_now;
  logic [CNT_W-1:0] load_val;
  logic [N_IN-1:0]  sync_lvl;
  logic             step_en, step_up;

  ec_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .reload_q(reload_q), .load_now(load_now), .load_val(load_val)
  );

  ec_sync #(.STAGES(SYNC_STAGES), .N(N_IN)) u_sync (
    .clk(clk), .rst(rst), .async_i({phb_i, dir_i, evt_i}), .sync_o(sync_lvl)
  );

  ec_step_sel u_step (
    .clk(clk), .rst(rst), .ctrl_q(ctrl_q),
    .a_lvl(sync_lvl[0]), .dir_lvl(sync_lvl[1]), .b_lvl(sync_lvl[2]),
    .step_en(step_en), .step_up(step_up)
  );

  ec_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .load_now(load_now), .load_val(load_val),
    .reload_q(reload_q), .step_en(step_en), .step_up(step_up),
    .pulse_en(ctrl_q.pulse_en),
    .cnt_q(count_o), .irq_q(irq_o), .pulse_q(pulse_o)
  );
endmodule

// File: rtl/ec_counter_chk.sv
module ec_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             wr_addr,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_o,
  input logic             pulse_o,
  input logic [5:0]       ctrl_bits,
  input logic [CNT_W-1:0] reload_q,
  input logic             load_now
);
  // R5: request coincides with the reloaded value (reload register not just rewritten)
  a_r5_irq_reload: assert property (@(posedge clk) disable iff (rst)
    irq_o && !$past(wr_en && wr_addr) |-> count_o == reload_q);

  // R9: stopped channel holds its value unless loaded
  a_r9_hold_stopped: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrl_bits[0]) && !$past(load_now) |-> $stable(count_o));

  // R9: a request needs the channel to have been running
  a_r9_irq_needs_run: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(ctrl_bits[0]));

  // R8: disabled pulse output reads low
  a_r8_pulse_off: assert property (@(posedge clk) disable iff (rst)
    !ctrl_bits[4] |=> !pulse_o);

  // R8: enabled pulse output only moves with a terminal event
  a_r8_pulse_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl_bits[4]) && !irq_o |-> $stable(pulse_o));

  // R12: single-step movement
  a_r12_one_step: assert property (@(posedge clk) disable iff (rst)
    !irq_o && !$past(load_now) |->
      (count_o == $past(count_o)) ||
      (count_o == CNT_W'($past(count_o) + 1'b1)) ||
      (count_o == CNT_W'($past(count_o) - 1'b1)));
endmodule

bind ec_counter_top ec_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .count_o(count_o), .irq_o(irq_o), .pulse_o(pulse_o),
  .ctrl_bits(ctrl_q), .reload_q(reload_q), .load_now(load_now)
);

// File: tb/tb_ec_counter_top.sv
module tb_ec_counter_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [15:0] wr_data = '0;
  logic        evt_i = 1'b0;
  logic        dir_i = 1'b0;
  logic        phb_i = 1'b0;
  logic [15:0] count_o;
  logic        irq_o, pulse_o;

  int n_chk = 0;
  int n_fail = 0;
  int irq_seen = 0;

  always #4 clk = ~clk;  // 125 MHz

  ec_counter_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .evt_i(evt_i), .dir_i(dir_i), .phb_i(phb_i),
    .count_o(count_o), .irq_o(irq_o), .pulse_o(pulse_o)
  );

  always @(negedge clk) if (!rst && irq_o) irq_seen++;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic evt_pulse();
    evt_i = 1'b1; repeat (5) @(negedge clk);
    evt_i = 1'b0; repeat (5) @(negedge clk);
  endtask

  task automatic pulses(input int k);
    for (int i = 0; i < k; i++) evt_pulse();
  endtask

  task automatic set_a(input logic v);
    evt_i = v; repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 count", count_o, 0);
    check("R1 irq", irq_o, 0);
    check("R1 pulse", pulse_o, 0);
    evt_pulse();
    check("R1 stopped after reset", count_o, 0);
  endtask

  task automatic t_down();
    int base;
    wr(1'b1, 16'd3);
    check("R2 load while stopped", count_o, 3);
    wr(1'b0, 16'h0003);
    base = irq_seen;
    pulses(3);
    check("R3 down reaches zero", count_o, 0);
    check("R3 no early irq", irq_seen - base, 0);
    pulses(1);
    check("R3 down reload", count_o, 3);
    check("R5 one irq per terminal", irq_seen - base, 1);
  endtask

  task automatic t_up();
    int base;
    wr(1'b0, 16'h0002);
    wr(1'b1, 16'hFFFC);
    check("R2 load FFFC", count_o, 16'hFFFC);
    wr(1'b0, 16'h000B);
    base = irq_seen;
    pulses(3);
    check("R4 up reaches top", count_o, 16'hFFFF);
    check("R4 no early irq", irq_seen - base, 0);
    pulses(1);
    check("R4 up reload", count_o, 16'hFFFC);
    check("R5 irq on up wrap", irq_seen - base, 1);
  endtask

  task automatic t_polarity();
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'd10);
    wr(1'b0, 16'h0001);  // run, falling edge, down
    set_a(1'b1);
    check("R6 rising ignored in falling mode", count_o, 10);
    set_a(1'b0);
    check("R6 falling counted", count_o, 9);
  endtask

  task automatic t_dir_pin();
    dir_i = 1'b1;
    repeat (4) @(negedge clk);
    wr(1'b0, 16'h0005);  // run, falling, direction from pin, sw bit down
    evt_pulse();
    check("R7 pin high counts up", count_o, 10);
    dir_i = 1'b0;
    repeat (4) @(negedge clk);
    evt_pulse();
    check("R7 pin low counts down", count_o, 9);
  endtask

  task automatic t_stop();
    wr(1'b0, 16'h0002);
    pulses(2);
    check("R9 stopped ignores events", count_o, 9);
  endtask

  task automatic t_pulse();
    wr(1'b1, 16'd1);
    wr(1'b0, 16'h0013);
    check("R8 pulse starts low", pulse_o, 0);
    pulses(2);
    check("R8 toggle on terminal", pulse_o, 1);
    check("R3 reload 1", count_o, 1);
    pulses(2);
    check("R8 toggle back", pulse_o, 0);
    pulses(2);
    check("R8 toggle again", pulse_o, 1);
    wr(1'b0, 16'h0003);
    repeat (2) @(negedge clk);
    check("R8 disabled output low", pulse_o, 0);
  endtask

  task automatic t_reload_running();
    wr(1'b1, 16'd5);
    check("R10 running write keeps count", count_o, 1);
    pulses(1);
    check("R10 count steps", count_o, 0);
    pulses(1);
    check("R10 new reload used", count_o, 5);
  endtask

  task automatic t_quad();
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'd100);
    dir_i = 1'b0;
    phb_i = 1'b0;
    wr(1'b0, 16'h002D);  // two-phase, run, sw up, pin direction
    set_a(1'b1);
    check("R11 rise with B low up", count_o, 101);
    set_a(1'b0);
    check("R11 fall counts down", count_o, 100);
    phb_i = 1'b1;
    repeat (4) @(negedge clk);
    set_a(1'b1);
    check("R11 rise with B high down", count_o, 99);
    set_a(1'b0);
    check("R11 fall with B high down", count_o, 98);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_down();
    t_up();
    t_polarity();
    t_dir_pin();
    t_stop();
    t_pulse();
    t_reload_running();
    t_quad();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule